// File: doc/BRIEF.md
# D-Channel Contention Transmit Gate

This block decides, port by port, whether the D-channel transmit shifter of a serial line port may put data on the wire. Software raises a per-port request bit, and that bit drives a request output toward the line transceiver. The grant that allows transmission comes from one of two places, chosen per port by a line-mode bit. In pin-grant mode it is the live level of a grant input from the transceiver. In register-grant mode it is a software grant bit, and the grant input is ignored. A per-port bypass bit lets the port send whatever the request and grant states are.

Each port holds a small transmit data register of `DBITS` bits and a shifter that sends one group of `DBITS` bits per frame, most significant bit first, on the clocks right after a frame sync strobe. The permission to shift is captured at the frame sync, so a change of grant takes effect only at the next frame boundary. A blocked port drives idle ones and keeps its data. Transmit and receive frame interrupt flags are set at every frame sync whether shifting is allowed or not, and software clears them by writing ones.

Top module: `dch_contention_gate`

## Requirements
- R1: A write to register address 0 sets the request bits (bit i is port i). On the following cycle `dreq` equals the value written.
- R2: When a port's mode bit (address 3) is 0, which is pin-grant mode, `grant_status` for that port follows the live `grant_pin` level.
- R3: When a port's mode bit is 1, which is register-grant mode, `grant_status` equals that port's grant bit (address 2), and `grant_pin` has no effect on the status or on transmission.
- R4: A port may shift when its request bit is 1 and its effective grant (pin or grant bit, depending on the mode) is 1.
- R5: When a port's bypass bit (address 1) is 1, the port shifts regardless of the request, grant and mode settings.
- R6: Permission to shift is sampled only at a `frame_sync` edge. A grant change during the bit slots does not alter the group being sent.
- R7: After a `frame_sync` edge, `dout` carries bit DBITS-1 of the loaded word on the first cycle, then the lower bits in order. Outside the bit slots, and in every slot of a blocked or empty port, `dout` is 1.
- R8: A frame that shifts consumes the loaded word, so `tx_empty` becomes 1. A blocked frame leaves the word loaded, so `tx_empty` stays 0. `tx_load` sets `tx_empty` to 0.
- R9: Every `frame_sync` edge sets all bits of `irq_tx` and `irq_rx`, whether any port is blocked or not. Writing ones to address 4 (transmit) or address 5 (receive) clears the selected bits. If a set and a clear happen in the same cycle, the set wins.
- R10: Synchronous reset clears the request, bypass, grant and mode bits and both interrupt flag sets, empties the data registers and deasserts `dreq`. After reset `dout` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Frame boundary strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 request, 1 bypass, 2 grant, 3 mode, 4 transmit-flag clear, 5 receive-flag clear |
| wr_data | input | N_PORTS | Write data, bit i for port i |
| tx_load | input | N_PORTS | Load strobe for each port's transmit data register |
| tx_data | input | N_PORTS*DBITS | Transmit words, port i in bits [i*DBITS +: DBITS] |
| grant_pin | input | N_PORTS | Grant inputs from the line transceiver |
| dreq | output | N_PORTS | Request outputs toward the transceiver |
| grant_status | output | N_PORTS | Effective grant for each port |
| tx_empty | output | N_PORTS | Transmit data register empty |
| dout | output | N_PORTS | Serial D-channel data, idle high |
| irq_tx | output | N_PORTS | Transmit frame interrupt flags |
| irq_rx | output | N_PORTS | Receive frame interrupt flags |

## Verification
The bench builds the block with two ports and two bits per frame. With that size it can sweep all 32 combinations of mode, request, grant bit, bypass bit and grant pin, with the two ports given opposite pin levels, and check the status, the serial bits, the idle level and whether the word was consumed against a gate equation computed in the bench. The small group width also brings into reach a grant drop between the two bit slots, a clear that arrives in the same cycle as a flag set, and a reset in the middle of a run.

// File: rtl/dch_pkg.sv
package dch_pkg;
   localparam int ADDR_W = 3;
   typedef enum logic [ADDR_W-1:0] {
      REG_REQ     = 3'd0,
      REG_BYPASS  = 3'd1,
      REG_GRANT   = 3'd2,
      REG_MODE    = 3'd3,
      REG_TXF_CLR = 3'd4,
      REG_RXF_CLR = 3'd5
   } dch_reg_e;
endpackage

// File: rtl/dch_grant_sel.sv
// Per-port grant source selection and shift permission.
module dch_grant_sel (
   input  logic mode_reg_grant,
   input  logic grant_bit,
   input  logic grant_pin,
   input  logic req,
   input  logic bypass,
   output logic status,
   output logic shift_ok
);
   always_comb begin
      status   = mode_reg_grant ? grant_bit : grant_pin;
      shift_ok = bypass | (req & status);
   end
endmodule

// File: rtl/dch_tx_shifter.sv
// One group of DBITS bits per frame, MSB first, idle high.
module dch_tx_shifter #(
   parameter int DBITS = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_sync,
   input  logic             shift_ok,
   input  logic             tx_load,
   input  logic [DBITS-1:0] tx_data,
   output logic             tx_empty,
   output logic             dout
);
   localparam int CW = $clog2(DBITS + 1);
   localparam logic [CW-1:0] SLOTS = CW'(DBITS);

   logic [DBITS-1:0] hold_q;
   logic [DBITS-1:0] shreg_q;
   logic [CW-1:0]    slots_q;
   logic             full_q;
   logic             take;

   assign take = frame_sync & shift_ok & full_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q  <= '0;
         shreg_q <= '1;
         slots_q <= '0;
         full_q  <= 1'b0;
      end else begin
         if (frame_sync) begin
            slots_q <= SLOTS;
            shreg_q <= take ? hold_q : '1;
         end else if (slots_q != '0) begin
            slots_q <= slots_q - 1'b1;
            shreg_q <= (shreg_q << 1) | DBITS'(1);
         end
         if (tx_load) begin
            hold_q <= tx_data;
            full_q <= 1'b1;
         end else if (take) begin
            full_q <= 1'b0;
         end
      end
   end

   assign tx_empty = ~full_q;
   assign dout     = (slots_q != '0) ? shreg_q[DBITS-1] : 1'b1;
endmodule

// File: rtl/dch_irq_flags.sv
// Sticky frame flags: set on frame sync, write-one-to-clear, set wins.
module dch_irq_flags #(
   parameter int N_PORTS = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               frame_sync,
   input  logic [N_PORTS-1:0] clr,
   output logic [N_PORTS-1:0] flags
);
   always_ff @(posedge clk) begin
      if (rst)             flags <= '0;
      else if (frame_sync) flags <= '1;
      else                 flags <= flags & ~clr;
   end
endmodule

// File: rtl/dch_contention_gate.sv
module dch_contention_gate #(
   parameter int N_PORTS = 4,
   parameter int DBITS   = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       frame_sync,
   input  logic                       wr_en,
   input  logic [2:0]                 wr_addr,
   input  logic [N_PORTS-1:0]         wr_data,
   input  logic [N_PORTS-1:0]         tx_load,
   input  logic [N_PORTS*DBITS-1:0]   tx_data,
   input  logic [N_PORTS-1:0]         grant_pin,
   output logic [N_PORTS-1:0]         dreq,
   output logic [N_PORTS-1:0]         grant_status,
   output logic [N_PORTS-1:0]         tx_empty,
   output logic [N_PORTS-1:0]         dout,
   output logic [N_PORTS-1:0]         irq_tx,
   output logic [N_PORTS-1:0]         irq_rx
);
   import dch_pkg::*;

   if (N_PORTS < 1) begin : g_bad_ports
      $error("N_PORTS must be at least 1");
   end
   if (DBITS < 1) begin : g_bad_dbits
      $error("DBITS must be at least 1");
   end

   logic [N_PORTS-1:0] req_q, bypass_q, grant_q, mode_q;
   logic [N_PORTS-1:0] shift_ok;
   logic [N_PORTS-1:0] clr_tx, clr_rx;
   dch_reg_e           sel;

   assign sel = dch_reg_e'(wr_addr);

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q    <= '0;
         bypass_q <= '0;
         grant_q  <= '0;
         mode_q   <= '0;
      end else if (wr_en) begin
         case (sel)
            REG_REQ:    req_q    <= wr_data;
            REG_BYPASS: bypass_q <= wr_data;
            REG_GRANT:  grant_q  <= wr_data;
            REG_MODE:   mode_q   <= wr_data;
            default: ;
         endcase
      end
   end

   assign clr_tx = (wr_en && sel == REG_TXF_CLR) ? wr_data : '0;
   assign clr_rx = (wr_en && sel == REG_RXF_CLR) ? wr_data : '0;
   assign dreq   = req_q;

   for (genvar i = 0; i < N_PORTS; i++) begin : g_port
      dch_grant_sel u_sel (
         .mode_reg_grant (mode_q[i]),
         .grant_bit      (grant_q[i]),
         .grant_pin      (grant_pin[i]),
         .req            (req_q[i]),
         .bypass         (bypass_q[i]),
         .status         (grant_status[i]),
         .shift_ok       (shift_ok[i])
      );
      dch_tx_shifter #(.DBITS(DBITS)) u_shf (
         .clk        (clk),
         .rst        (rst),
         .frame_sync (frame_sync),
         .shift_ok   (shift_ok[i]),
         .tx_load    (tx_load[i]),
         .tx_data    (tx_data[i*DBITS +: DBITS]),
         .tx_empty   (tx_empty[i]),
         .dout       (dout[i])
      );
   end

   dch_irq_flags #(.N_PORTS(N_PORTS)) u_txf (
      .clk (clk), .rst (rst), .frame_sync (frame_sync), .clr (clr_tx), .flags (irq_tx)
   );
   dch_irq_flags #(.N_PORTS(N_PORTS)) u_rxf (
      .clk (clk), .rst (rst), .frame_sync (frame_sync), .clr (clr_rx), .flags (irq_rx)
   );
endmodule

// File: rtl/dch_contention_gate_chk.sv
module dch_contention_gate_chk #(
   parameter int N_PORTS = 4,
   parameter int DBITS   = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               frame_sync,
   input logic               wr_en,
   input logic [2:0]         wr_addr,
   input logic [N_PORTS-1:0] wr_data,
   input logic [N_PORTS-1:0] dreq,
   input logic [N_PORTS-1:0] dout,
   input logic [N_PORTS-1:0] tx_empty,
   input logic [N_PORTS-1:0] tx_load,
   input logic [N_PORTS-1:0] shift_ok,
   input logic [N_PORTS-1:0] mode_q,
   input logic [N_PORTS-1:0] grant_q,
   input logic [N_PORTS-1:0] grant_status,
   input logic [N_PORTS-1:0] irq_tx,
   input logic [N_PORTS-1:0] irq_rx
);
   localparam int SW = $clog2(DBITS + 2);
   localparam logic [SW-1:0] IDLE_AT = SW'(DBITS);

   logic [SW-1:0] since_fs;
   always_ff @(posedge clk) begin
      if (rst)                      since_fs <= IDLE_AT;
      else if (frame_sync)          since_fs <= '0;
      else if (since_fs < IDLE_AT)  since_fs <= since_fs + 1'b1;
   end

   a_r1_dreq_tracks_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == 3'd0) |=> (dreq == $past(wr_data)));

   a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
      (since_fs >= IDLE_AT) |-> (dout == '1));

   a_r9_flags_set: assert property (@(posedge clk) disable iff (rst)
      frame_sync |=> ((irq_tx == '1) && (irq_rx == '1)));

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> ((dreq == '0) && (irq_tx == '0) && (tx_empty == '1)));

   for (genvar i = 0; i < N_PORTS; i++) begin : g_p
      a_r8_keep_when_blocked: assert property (@(posedge clk) disable iff (rst)
         (frame_sync && !shift_ok[i] && !tx_empty[i] && !tx_load[i]) |=> !tx_empty[i]);
      a_r8_take_when_open: assert property (@(posedge clk) disable iff (rst)
         (frame_sync && shift_ok[i] && !tx_empty[i] && !tx_load[i]) |=> tx_empty[i]);
      a_r3_pin_ignored: assert property (@(posedge clk) disable iff (rst)
         (mode_q[i] && $past(mode_q[i]) && $stable(grant_q[i])) |-> $stable(grant_status[i]));
   end
endmodule

bind dch_contention_gate dch_contention_gate_chk #(.N_PORTS(N_PORTS), .DBITS(DBITS)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .frame_sync   (frame_sync),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .dreq         (dreq),
   .dout         (dout),
   .tx_empty     (tx_empty),
   .tx_load      (tx_load),
   .shift_ok     (shift_ok),
   .mode_q       (mode_q),
   .grant_q      (grant_q),
   .grant_status (grant_status),
   .irq_tx       (irq_tx),
   .irq_rx       (irq_rx)
);

// File: tb/tb_dch_contention_gate.sv
module tb_dch_contention_gate;
   localparam int N  = 2;
   localparam int DB = 2;
   localparam int CLK_PERIOD = 10;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           frame_sync = 1'b0;
   logic           wr_en = 1'b0;
   logic [2:0]     wr_addr = '0;
   logic [N-1:0]   wr_data = '0;
   logic [N-1:0]   tx_load = '0;
   logic [N*DB-1:0] tx_data = '0;
   logic [N-1:0]   grant_pin = '0;
   logic [N-1:0]   dreq, grant_status, tx_empty, dout, irq_tx, irq_rx;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   dch_contention_gate #(.N_PORTS(N), .DBITS(DB)) dut (
      .clk, .rst, .frame_sync, .wr_en, .wr_addr, .wr_data, .tx_load, .tx_data,
      .grant_pin, .dreq, .grant_status, .tx_empty, .dout, .irq_tx, .irq_rx
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load(input logic [N*DB-1:0] d);
      @(negedge clk);
      tx_load = '1; tx_data = d;
      @(negedge clk);
      tx_load = '0;
   endtask

   task automatic run_frame(output logic [N-1:0] b1, output logic [N-1:0] b0,
                            output logic [N-1:0] idle);
      @(negedge clk);
      frame_sync = 1'b1;
      @(negedge clk);
      frame_sync = 1'b0;
      b1 = dout;
      @(negedge clk);
      b0 = dout;
      @(negedge clk);
      idle = dout;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] b1, b0, idle;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10 reset state
      chk(dreq == '0, "R10 dreq", int'(dreq), 0);
      chk(tx_empty == '1, "R10 tx_empty", int'(tx_empty), 3);
      chk(irq_tx == '0 && irq_rx == '0, "R10 irq", int'({irq_tx, irq_rx}), 0);
      chk(dout == '1, "R10 dout", int'(dout), 3);

      // Sweep all gate input combinations; port 1 sees the inverted pin.
      for (int c = 0; c < 32; c++) begin
         logic mode, rq, gb, byp, pin;
         logic [N-1:0] pins, exp_st, en;
         logic [DB-1:0] d0, d1;
         mode = c[0]; rq = c[1]; gb = c[2]; byp = c[3]; pin = c[4];
         pins = {~pin, pin};
         reg_wr(3'd3, {N{mode}});
         reg_wr(3'd0, {N{rq}});
         reg_wr(3'd2, {N{gb}});
         reg_wr(3'd1, {N{byp}});
         d0 = DB'(c); d1 = DB'(c + 1);
         grant_pin = pins;
         load({d1, d0});
         for (int p = 0; p < N; p++) begin
            exp_st[p] = mode ? gb : pins[p];
            en[p] = byp | (rq & exp_st[p]);
         end
         chk(dreq == {N{rq}}, "R1 dreq", int'(dreq), int'({N{rq}}));
         chk(grant_status == exp_st, mode ? "R3 status" : "R2 status",
             int'(grant_status), int'(exp_st));
         chk(tx_empty == '0, "R8 loaded", int'(tx_empty), 0);
         run_frame(b1, b0, idle);
         for (int p = 0; p < N; p++) begin
            logic [DB-1:0] w, got;
            w = (p == 0) ? d0 : d1;
            if (!en[p]) w = '1;
            got = {b1[p], b0[p]};
            chk(got == w, byp ? "R5 bits" : "R4 bits", int'(got), int'(w));
            chk(tx_empty[p] == en[p], "R8 consume", int'(tx_empty[p]), int'(en[p]));
         end
         chk(idle == '1, "R7 idle", int'(idle), 3);
         chk(irq_tx == '1 && irq_rx == '1, "R9 set", int'({irq_tx, irq_rx}), 15);
         reg_wr(3'd4, 2'b01);
         chk(irq_tx == 2'b10 && irq_rx == '1, "R9 tx clear", int'({irq_tx, irq_rx}), 11);
         reg_wr(3'd5, 2'b11);
         reg_wr(3'd4, 2'b10);
         chk(irq_tx == '0 && irq_rx == '0, "R9 all clear", int'({irq_tx, irq_rx}), 0);
      end

      // R6 grant drops between bit slots: the group is still sent whole.
      reg_wr(3'd3, 2'b00);
      reg_wr(3'd1, 2'b00);
      reg_wr(3'd0, 2'b11);
      grant_pin = 2'b11;
      load({2'b10, 2'b01});
      @(negedge clk);
      frame_sync = 1'b1;
      @(negedge clk);
      frame_sync = 1'b0;
      grant_pin = 2'b00;
      b1 = dout;
      @(negedge clk);
      b0 = dout;
      chk({b1[0], b0[0]} == 2'b01, "R6 port0 whole", int'({b1[0], b0[0]}), 1);
      chk({b1[1], b0[1]} == 2'b10, "R6 port1 whole", int'({b1[1], b0[1]}), 2);
      // Next frame with the pin low: blocked, word kept.
      load({2'b00, 2'b00});
      run_frame(b1, b0, idle);
      chk(b1 == '1 && b0 == '1, "R6 next frame blocked", int'({b1, b0}), 15);
      chk(tx_empty == '0, "R8 kept", int'(tx_empty), 0);

      // R9 clear in the same cycle as frame sync: set wins.
      reg_wr(3'd4, 2'b11);
      @(negedge clk);
      frame_sync = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 2'b11;
      @(negedge clk);
      frame_sync = 1'b0; wr_en = 1'b0;
      chk(irq_tx == '1, "R9 set wins", int'(irq_tx), 3);
      repeat (3) @(negedge clk);

      // R10 reset in mid-run.
      reg_wr(3'd1, 2'b11);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(dreq == '0, "R10 dreq after run", int'(dreq), 0);
      chk(tx_empty == '1, "R10 empty after run", int'(tx_empty), 3);
      chk(irq_tx == '0, "R10 irq after run", int'(irq_tx), 0);
      load({2'b00, 2'b00});
      run_frame(b1, b0, idle);
      chk(b1 == '1 && b0 == '1, "R10 shifting off", int'({b1, b0}), 15);
      chk(tx_empty == '0, "R10 word kept", int'(tx_empty), 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule